// File: doc/BRIEF.md
# Double-Buffered Center-Aligned PWM Timer

This block is a single-channel PWM timer. It has a counter, a period limit and one compare level. Software writes the period and the compare level into shadow copies. The counter only uses the working copies, and these are refreshed from the shadows at an update event. An update event happens at the counter's turning or wrap point, or at once when software asks for it. Because of this, a new period or duty is never applied partway through a cycle, and the output does not glitch.

There are two counting modes. In edge mode the counter rises from zero to the period and then wraps. In center mode it runs up to the period and back down to zero, which gives symmetric pulses. In both modes the output is high while the counter is below the compare level.

Software writes the counter directly through the same write port. In center mode, the value written decides how the direction bit reacts. A software update loads the shadows, restarts the counter and emits an event pulse, so it is the safe way to start the timer.

Top module: `pwm_timer_dbuf`

## Requirements
- R1: Writes to address 0 (period shadow) and address 1 (compare shadow) leave the working period and compare unchanged until the next update event. The running cycle therefore completes with its old values.
- R2: Edge mode (control bit 2 = 0), enabled: the counter steps +1 per clock while below the working period. At or above the period it returns to 0, the shadows are loaded and `updEvt` pulses for one cycle. One PWM cycle therefore lasts period+1 clocks.
- R3: Center mode (control bit 2 = 1), enabled, direction up: reaching the period turns the direction down and steps the counter −1. Direction down: reaching 0 turns the direction up and steps +1. Each turn loads the shadows and pulses `updEvt`.
- R4: `pwmOut` is high exactly when the timer is enabled and the counter is below the working compare. A compare of 0 therefore gives a constant low, and a compare above the period gives a constant high.
- R5: A counter write (address 2) in center mode loads the counter. A value of 0 sets the direction up. A value equal to the working period sets the direction down. Neither case pulses `updEvt`.
- R6: A counter write in center mode with a value above the working period leaves the direction unchanged.
- R7: Control write (address 3): bit 0 is enable, bit 1 is direction (1 = down) and bit 2 is mode (1 = center). If a single write changes both direction and mode, the direction is kept and only the mode and enable are applied. Otherwise the direction bit is applied.
- R8: Any write to address 4 is a software update. It loads both shadows and sets the counter to the new period when the timer is in center mode with direction down, and to 0 otherwise. It also pulses `updEvt` in the next cycle, whether or not the timer is enabled.
- R9: While disabled, the counter holds and `pwmOut` is low. Shadow writes are still accepted.
- R10: After reset the counter is 0, the direction is up, the timer is disabled in edge mode, all registers are 0, and `pwmOut` and `updEvt` are low.
- R11: A write to address 2, 3 or 4 takes that clock cycle, and the counter does not also step. Shadow writes do not stall counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: 0 period shadow, 1 compare shadow, 2 counter, 3 control, 4 software update |
| wrData | input | CNT_W | Write data |
| pwmOut | output | 1 | PWM output |
| updEvt | output | 1 | One-cycle update event pulse |
| cntVal | output | CNT_W | Current counter value |
| cntDown | output | 1 | Current count direction, 1 = down |

## Verification
The bench builds the timer with an 8-bit counter (CNT_W = 8). Counter values written above a small period, such as 10 and 12 against a period of 6, therefore stay inside the counter's range. Small periods (5, 6 and 9) let many complete edge and center cycles fit into a short run. A compare of 200 against a period of 5 exercises the always-high case. Every clock, a behavioural model compares the counter, direction, output and event pulse. This covers the center-mode counter writes at 0, at the period and above it, and the control write that flips mode and direction together.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_PER = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_UPD = 3'd4;

  // control word bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_DIR = 1;
  localparam int CTL_CTR = 2;

  typedef struct packed {
    logic ldPrePer;
    logic ldPreCmp;
    logic ldCnt;
    logic xfer;
    logic cntClr;
    logic cntLdTop;
    logic cntInc;
    logic cntDec;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             enIn,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] actPer,
  output logic             pwmOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] prePer;
  logic [CNT_W-1:0] preCmp;
  logic [CNT_W-1:0] actCmp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prePer <= '0;
      preCmp <= '0;
      actPer <= '0;
      actCmp <= '0;
      cnt    <= '0;
    end else begin
      if (strobe.ldPrePer) prePer <= wrData;
      if (strobe.ldPreCmp) preCmp <= wrData;
      if (strobe.xfer) begin
        actPer <= prePer;
        actCmp <= preCmp;
      end
      if (strobe.ldCnt)         cnt <= wrData;
      else if (strobe.cntLdTop) cnt <= prePer;
      else if (strobe.cntClr)   cnt <= '0;
      else if (strobe.cntInc)   cnt <= cnt + ONE;
      else if (strobe.cntDec)   cnt <= cnt - ONE;
    end
  end

  assign pwmOut = enIn && (cnt < actCmp);

  // R1
  keep_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xfer |=> ($stable(actPer) && $stable(actCmp)));

  // R9
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enIn && !strobe.ldCnt && !strobe.cntLdTop && !strobe.cntClr) |=> $stable(cnt));

  // R4
  zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actCmp == '0) |-> !pwmOut);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  actPer,
  output pwmStrobe_t        strobe,
  output logic              enOut,
  output logic              downOut,
  output logic              updEvt
);
  logic enQ, ctrQ, downQ;
  logic enNext, ctrNext, downNext, evt;
  logic swHit, cntHit, ctlHit;

  assign swHit  = wrEn && (wrAddr == ADDR_UPD);
  assign cntHit = wrEn && (wrAddr == ADDR_CNT);
  assign ctlHit = wrEn && (wrAddr == ADDR_CTL);

  always_comb begin
    strobe   = '0;
    evt      = 1'b0;
    enNext   = enQ;
    ctrNext  = ctrQ;
    downNext = downQ;
    strobe.ldPrePer = wrEn && (wrAddr == ADDR_PER);
    strobe.ldPreCmp = wrEn && (wrAddr == ADDR_CMP);
    if (swHit) begin
      strobe.xfer = 1'b1;
      evt         = 1'b1;
      if (ctrQ && downQ) strobe.cntLdTop = 1'b1;
      else               strobe.cntClr   = 1'b1;
    end else if (cntHit) begin
      strobe.ldCnt = 1'b1;
      if (ctrQ) begin
        if (wrData == '0)          downNext = 1'b0;
        else if (wrData == actPer) downNext = 1'b1;
      end
    end else if (ctlHit) begin
      enNext  = wrData[CTL_EN];
      ctrNext = wrData[CTL_CTR];
      if (!((wrData[CTL_DIR] != downQ) && (wrData[CTL_CTR] != ctrQ)))
        downNext = wrData[CTL_DIR];
    end else if (enQ) begin
      if (!ctrQ) begin
        if (cnt >= actPer) begin
          strobe.cntClr = 1'b1;
          strobe.xfer   = 1'b1;
          evt           = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end else if (!downQ) begin
        if (cnt >= actPer) begin
          strobe.xfer = 1'b1;
          evt         = 1'b1;
          downNext    = 1'b1;
          if (cnt != '0) strobe.cntDec = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          strobe.xfer   = 1'b1;
          evt           = 1'b1;
          downNext      = 1'b0;
          strobe.cntInc = 1'b1;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      ctrQ   <= 1'b0;
      downQ  <= 1'b0;
      updEvt <= 1'b0;
    end else begin
      enQ    <= enNext;
      ctrQ   <= ctrNext;
      downQ  <= downNext;
      updEvt <= evt;
    end
  end

  assign enOut   = enQ;
  assign downOut = downQ;

  // R5
  cnt_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntHit |=> !updEvt);

  // R8
  sw_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    swHit |=> updEvt);

  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlHit && (wrData[CTL_DIR] != downQ) && (wrData[CTL_CTR] != ctrQ))
      |=> (downQ == $past(downQ)));

  // R6
  above_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntHit && ctrQ && (wrData > actPer)) |=> $stable(downQ));

  // R2
  edge_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !ctrQ && !swHit && !cntHit && !ctlHit && (cnt >= actPer)) |=> (updEvt && (cnt == '0)));
endmodule

// File: rtl/pwm_timer_dbuf.sv
module pwm_timer_dbuf
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic             updEvt,
  output logic [CNT_W-1:0] cntVal,
  output logic             cntDown
);
  pwmStrobe_t       strobe;
  logic             enSig;
  logic [CNT_W-1:0] cntSig;
  logic [CNT_W-1:0] actPerSig;

  pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cnt    (cntSig),
    .actPer (actPerSig),
    .strobe (strobe),
    .enOut  (enSig),
    .downOut(cntDown),
    .updEvt (updEvt)
  );

  pwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .enIn   (enSig),
    .cnt    (cntSig),
    .actPer (actPerSig),
    .pwmOut (pwmOut)
  );

  assign cntVal = cntSig;
endmodule

// File: tb/pwm_timer_dbuf_test.sv
module pwm_timer_dbuf_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic         pwmOut, updEvt, cntDown;
  logic [W-1:0] cntVal;

  always #2.5 clk = ~clk;   // 200 MHz

  pwm_timer_dbuf #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .updEvt(updEvt), .cntVal(cntVal), .cntDown(cntDown)
  );

  int nChk = 0, nBad = 0, cycles = 0;
  bit done = 0;
  string curReq = "R10";

  // behavioural reference model
  int mCnt, mPer, mCmp, mPP, mPC, nPP, nPC;
  bit mDown, mEn, mCtr, mEvt, ev;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPer = 0; mCmp = 0; mPP = 0; mPC = 0;
      mDown = 0; mEn = 0; mCtr = 0; mEvt = 0;
    end else begin
      ev = 0; nPP = mPP; nPC = mPC;
      if (wrEn && wrAddr == 0) nPP = int'(wrData);
      if (wrEn && wrAddr == 1) nPC = int'(wrData);
      if (wrEn && wrAddr == 4) begin
        mPer = mPP; mCmp = mPC; ev = 1;
        mCnt = (mCtr && mDown) ? mPP : 0;
      end else if (wrEn && wrAddr == 2) begin
        mCnt = int'(wrData);
        if (mCtr) begin
          if (mCnt == 0) mDown = 0;
          else if (mCnt == mPer) mDown = 1;
        end
      end else if (wrEn && wrAddr == 3) begin
        mEn = wrData[0];
        if (!(wrData[1] != mDown && wrData[2] != mCtr)) mDown = wrData[1];
        mCtr = wrData[2];
      end else if (mEn) begin
        if (!mCtr) begin
          if (mCnt >= mPer) begin mCnt = 0; mPer = mPP; mCmp = mPC; ev = 1; end
          else mCnt++;
        end else if (!mDown) begin
          if (mCnt >= mPer) begin
            mPer = mPP; mCmp = mPC; ev = 1; mDown = 1;
            if (mCnt > 0) mCnt--;
          end else mCnt++;
        end else begin
          if (mCnt == 0) begin mPer = mPP; mCmp = mPC; ev = 1; mDown = 0; mCnt = 1; end
          else mCnt--;
        end
      end
      mPP = nPP; mPC = nPC; mEvt = ev;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmpAll();
    chk({curReq, " cnt"}, int'(cntVal), mCnt);
    chk({curReq, " dir"}, int'(cntDown), int'(mDown));
    chk({curReq, " pwm"}, int'(pwmOut), int'(mEn && (mCnt < mCmp)));
    chk({curReq, " evt"}, int'(updEvt), int'(mEvt));
  endtask

  task automatic cyc();
    @(negedge clk);
    cmpAll();
  endtask

  task automatic wr(int a, int d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = W'(d);
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    int evCnt, cSave, bad, saw;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk("R10 cnt", int'(cntVal), 0);
    chk("R10 pwm", int'(pwmOut), 0);
    chk("R10 evt", int'(updEvt), 0);
    chk("R10 dir", int'(cntDown), 0);
    cyc();

    // R8 software update while disabled, then R2 edge mode
    curReq = "R8";
    wr(0, 9); wr(1, 4); wr(4, 0);
    chk("R8 cnt after sw update", int'(cntVal), 0);
    chk("R8 evt after sw update", int'(updEvt), 1);
    curReq = "R2";
    wr(3, 1);
    evCnt = 0;
    for (int i = 0; i < 30; i++) begin cyc(); evCnt += int'(updEvt); end
    chk("R2 wraps in 30 cycles", evCnt, 3);

    // R1 mid-period change completes the old period; R11 shadow writes do not stall
    curReq = "R1";
    repeat (3) cyc();
    wr(0, 5); wr(1, 2);
    chk("R11 count kept moving", int'(cntVal), 5);
    saw = 0;
    for (int i = 0; i < 6; i++) begin cyc(); if (cntVal == 9) saw = 1; end
    chk("R1 old period reached 9", saw, 1);
    evCnt = 0;
    for (int i = 0; i < 20; i++) begin cyc(); evCnt++; if (updEvt) break; end
    chk("R2 new period length", evCnt, 5);

    // R4 compare extremes
    curReq = "R4";
    wr(1, 0); wr(4, 0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin cyc(); bad += int'(pwmOut); end
    chk("R4 compare 0 constant low", bad, 0);
    wr(1, 200); wr(4, 0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin cyc(); bad += int'(!pwmOut); end
    chk("R4 compare above period constant high", bad, 0);

    // R9 disabled hold
    curReq = "R9";
    wr(3, 0);
    cSave = int'(cntVal);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      if (int'(cntVal) != cSave || pwmOut) bad++;
    end
    chk("R9 hold and low", bad, 0);
    wr(0, 6); wr(1, 3);
    chk("R9 cnt held over shadow writes", int'(cntVal), cSave);

    // R3 center mode
    curReq = "R3";
    wr(3, 5); wr(4, 0);
    chk("R8 center up restart", int'(cntVal), 0);
    evCnt = 0;
    for (int i = 0; i < 24; i++) begin cyc(); evCnt += int'(updEvt); end
    chk("R3 turning events", evCnt, 3);
    chk("R3 direction down at bottom", int'(cntDown), 1);
    cyc(); cyc();
    chk("R3 turned up", int'(cntDown), 0);

    // R5 counter writes at period and 0
    curReq = "R5";
    wr(2, 6);
    chk("R5 write period dir", int'(cntDown), 1);
    chk("R5 write period evt", int'(updEvt), 0);
    cyc();
    wr(2, 0);
    chk("R5 write zero dir", int'(cntDown), 0);
    chk("R5 write zero evt", int'(updEvt), 0);
    cyc();

    // R6 counter write above period
    curReq = "R6";
    wr(2, 10);
    chk("R6 above keeps up", int'(cntDown), 0);
    cyc();
    chk("R6 turn after above", int'(updEvt), 1);
    chk("R6 cnt after turn", int'(cntVal), 9);
    wr(2, 12);
    chk("R6 above keeps down", int'(cntDown), 1);
    cyc();
    chk("R6 still down", int'(cntVal), 11);

    // R8 software update in center mode counting down
    curReq = "R8";
    wr(4, 0);
    chk("R8 center down restart cnt", int'(cntVal), 6);
    chk("R8 center down evt", int'(updEvt), 1);

    // R7 mode and direction changed together
    curReq = "R7";
    wr(3, 1);
    chk("R7 dir kept on joint change", int'(cntDown), 1);
    repeat (4) cyc();
    wr(3, 1);
    chk("R7 same-write dir change ignored again? no: mode same, dir applied", int'(cntDown), 0);
    for (int i = 0; i < 20; i++) cyc();

    finishRun();
  end
endmodule